// File: doc/BRIEF.md
# Carry-Controlled Ripple Add/Subtract Unit

This block is a combinational two's-complement adder/subtractor built from a chain of identical one-bit stages. The carry is passed from stage to stage inside the block. The single carry input has two jobs at once. When it is low, the unit adds its two operands. When it is high, every bit of the second operand is inverted before it enters the adders, and the same high value enters the least significant stage as the +1 that two's-complement subtraction needs.

Bit 0 is the least significant bit. The carry runs from bit 0 up to the top bit, and the carry leaving the top stage is the only carry the block drives out. In subtract mode that carry is high exactly when no borrow happened. Results wrap modulo 2^WIDTH. The block does no saturation and no overflow detection. The width is a parameter that defaults to 8.

Top module: `ripple_addsub`

## Requirements
- R1: With carry_mode_in = 0, the concatenation {carry_out, result} equals opnd_x + opnd_y as a (WIDTH+1)-bit unsigned sum.
- R2: With carry_mode_in = 1, result equals (opnd_x - opnd_y) modulo 2^WIDTH.
- R3: With carry_mode_in = 1, carry_out is 1 exactly when opnd_x >= opnd_y as unsigned numbers, and 0 when a borrow occurs.
- R4: A carry produced in bit 0 reaches carry_out through every stage: all-ones plus one in add mode gives result 0 with carry_out 1.
- R5: Subtracting zero (carry_mode_in = 1, opnd_y = 0) returns opnd_x unchanged with carry_out 1, because the injected +1 ripples out of the top stage.
- R6: Results wrap with no saturation: in add mode 0x7F + 0x01 gives 0x80 with carry_out 0, and in subtract mode 0x80 - 0x01 gives 0x7F with carry_out 1 (values for WIDTH = 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | WIDTH | First operand (minuend in subtract mode) |
| opnd_y | input | WIDTH | Second operand (subtrahend in subtract mode) |
| carry_mode_in | input | 1 | 0 selects add with no carry in; 1 selects subtract and supplies the +1 |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry from the most significant stage (1 means no borrow when subtracting) |

## Verification
The block holds no state, so a fault in the chain of internal carries or in the operand inversion shows at the ports as soon as the inputs settle. A carry that is lost or stuck in one stage corrupts that result bit and every higher bit, and the effect reaches carry_out only for operand pairs that propagate through the faulty stage. For this reason the bench applies every operand pair in both modes and does not rely on sampled values alone. A fault in the inversion, or in how the mode bit enters stage 0, appears only in subtract mode, and there it shows as a difference that is off by the second operand or off by one.

// File: rtl/addsub_pkg.sv
// Package: shared constants for the ripple add/subtract unit.
// Assumes: nothing beyond a default operand width of eight bits.
package addsub_pkg;
    localparam int unsigned ADDSUB_DEFAULT_W = 8;
endpackage : addsub_pkg

// File: rtl/addsub_full_adder.sv
// Module: one-bit full adder.
// Does: forms the sum and carry of three input bits.
// Assumes: purely combinational use; no timing element inside.
module addsub_full_adder (
    input  logic in_p,
    input  logic in_q,
    input  logic in_c,
    output logic sum_o,
    output logic carry_o
);
    logic half_x;

    // Sum and majority carry of the three inputs.
    always_comb begin
        half_x  = in_p ^ in_q;
        sum_o   = half_x ^ in_c;
        carry_o = (in_p & in_q) | (in_c & half_x);
    end
endmodule : addsub_full_adder

// File: rtl/addsub_stage.sv
// Module: one bit slice of the add/subtract chain.
// Does: conditionally inverts the second-operand bit under the shared mode
//       bit, then adds it to the first-operand bit and the incoming carry.
// Assumes: mode_i is the same global carry-in seen by every slice.
module addsub_stage (
    input  logic x_i,
    input  logic y_i,
    input  logic mode_i,
    input  logic cin_i,
    output logic s_o,
    output logic cout_o
);
    logic y_cond;

    // Invert the second-operand bit when subtracting.
    always_comb y_cond = y_i ^ mode_i;

    addsub_full_adder u_fa (
        .in_p    (x_i),
        .in_q    (y_cond),
        .in_c    (cin_i),
        .sum_o   (s_o),
        .carry_o (cout_o)
    );
endmodule : addsub_stage

// File: rtl/ripple_addsub.sv
// Module: WIDTH-bit ripple-carry adder/subtractor with carry-controlled mode.
// Does: result = x + y when carry_mode_in = 0, x - y (two's complement) when 1;
//       carry_out is the carry leaving the most significant slice.
// Assumes: combinational block; bit 0 is the least significant bit; the
//          carry chain is internal and runs upward from bit 0.
module ripple_addsub
    import addsub_pkg::*;
#(
    parameter int unsigned WIDTH = ADDSUB_DEFAULT_W
) (
    input  logic [WIDTH-1:0] opnd_x,
    input  logic [WIDTH-1:0] opnd_y,
    input  logic             carry_mode_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int unsigned CHAIN_N = WIDTH + 1;

    logic [CHAIN_N-1:0] chain_c;

    // Seed the chain: the mode bit is also the +1 for subtraction.
    always_comb chain_c[0] = carry_mode_in;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
        addsub_stage u_stage (
            .x_i    (opnd_x[gi]),
            .y_i    (opnd_y[gi]),
            .mode_i (carry_mode_in),
            .cin_i  (chain_c[gi]),
            .s_o    (result[gi]),
            .cout_o (chain_c[gi+1])
        );
    end

    // Export the carry of the top slice.
    always_comb carry_out = chain_c[CHAIN_N-1];
endmodule : ripple_addsub

// File: rtl/ripple_addsub_chk.sv
// Module: assertion checker for ripple_addsub, attached by bind below.
// Does: compares port values against arithmetic reference relations.
// Assumes: inputs are settled whenever the combinational process re-evaluates.
module ripple_addsub_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic [WIDTH-1:0] opnd_x,
    input logic [WIDTH-1:0] opnd_y,
    input logic             carry_mode_in,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    logic [WIDTH:0]   ref_sum;
    logic [WIDTH-1:0] ref_diff;

    // Reference arithmetic and port checks.
    always_comb begin
        ref_sum  = {1'b0, opnd_x} + {1'b0, opnd_y};
        ref_diff = opnd_x - opnd_y;
        if (!carry_mode_in) begin
            assert_add_sum_R1: assert ({carry_out, result} == ref_sum)
                else $error("R1 add mismatch");
        end
        if (carry_mode_in) begin
            assert_sub_diff_R2: assert (result == ref_diff)
                else $error("R2 difference mismatch");
            assert_no_borrow_R3: assert (carry_out == (opnd_x >= opnd_y))
                else $error("R3 borrow flag mismatch");
        end
        if (!carry_mode_in && (&opnd_x) && (opnd_y == WIDTH'(1))) begin
            assert_full_ripple_R4: assert (result == '0 && carry_out)
                else $error("R4 ripple did not reach top");
        end
        if (carry_mode_in && (opnd_y == '0)) begin
            assert_sub_zero_R5: assert (result == opnd_x && carry_out)
                else $error("R5 subtract zero mismatch");
        end
    end
endmodule : ripple_addsub_chk

bind ripple_addsub ripple_addsub_chk #(.WIDTH(WIDTH)) u_chk (
    .opnd_x        (opnd_x),
    .opnd_y        (opnd_y),
    .carry_mode_in (carry_mode_in),
    .result        (result),
    .carry_out     (carry_out)
);

// File: tb/ripple_addsub_tb.sv
module ripple_addsub_tb;
    localparam int W = 8;
    localparam int NVEC = 13;
    // Entry: {x[8], y[8], mode, expected result[8], expected carry}
    localparam logic [25:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 1'b0, 8'h00, 1'b0},
        {8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},
        {8'h80, 8'h80, 1'b0, 8'h00, 1'b1},
        {8'h7F, 8'h01, 1'b0, 8'h80, 1'b0},
        {8'hFF, 8'hFF, 1'b0, 8'hFE, 1'b1},
        {8'hA5, 8'h5A, 1'b0, 8'hFF, 1'b0},
        {8'h00, 8'h00, 1'b1, 8'h00, 1'b1},
        {8'h00, 8'h01, 1'b1, 8'hFF, 1'b0},
        {8'h05, 8'h03, 1'b1, 8'h02, 1'b1},
        {8'h03, 8'h05, 1'b1, 8'hFE, 1'b0},
        {8'h80, 8'h01, 1'b1, 8'h7F, 1'b1},
        {8'hFF, 8'hFF, 1'b1, 8'h00, 1'b1},
        {8'h00, 8'hFF, 1'b1, 8'h01, 1'b0}
    };

    logic         clk = 1'b0;
    logic [W-1:0] x, y, res;
    logic         mode, cout;
    int           checks = 0;
    int           errors = 0;
    int           cycles = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    ripple_addsub #(.WIDTH(W)) u_dut (
        .opnd_x        (x),
        .opnd_y        (y),
        .carry_mode_in (mode),
        .result        (res),
        .carry_out     (cout)
    );

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s x=%h y=%h mode=%b actual=%h expected=%h", req, x, y, mode, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] ax, input logic [W-1:0] ay, input logic am);
        x = ax; y = ay; mode = am;
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        x = '0; y = '0; mode = 1'b0;
        #1;
        // Table of corner vectors (R1 add rows, R2/R3 subtract rows).
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][25:18], VEC[i][17:10], VEC[i][9]);
            if (VEC[i][9]) check("R2_R3 table", {cout, res}, {VEC[i][0], VEC[i][8:1]});
            else           check("R1 table",    {cout, res}, {VEC[i][0], VEC[i][8:1]});
        end
        // Directed: R4 full carry ripple.
        apply(8'hFF, 8'h01, 1'b0);
        check("R4 ripple", {cout, res}, 9'h100);
        // Directed: R5 subtract zero.
        apply(8'h3C, 8'h00, 1'b1);
        check("R5 minus zero", {cout, res}, 9'h13C);
        apply(8'h00, 8'h00, 1'b1);
        check("R5 zero minus zero", {cout, res}, 9'h100);
        // Directed: R6 wrap without saturation.
        apply(8'h7F, 8'h01, 1'b0);
        check("R6 add wrap", {cout, res}, 9'h080);
        apply(8'h80, 8'h01, 1'b1);
        check("R6 sub wrap", {cout, res}, 9'h17F);
        // Exhaustive sweep: R1 add, R2 difference, R3 no-borrow flag.
        for (int ix = 0; ix < 256; ix++) begin
            for (int iy = 0; iy < 256; iy++) begin
                apply(ix[7:0], iy[7:0], 1'b0);
                check("R1 sweep", {cout, res}, 9'(ix + iy));
                apply(ix[7:0], iy[7:0], 1'b1);
                check("R2 sweep", {1'b0, res}, {1'b0, 8'(ix - iy)});
                check("R3 sweep", {8'h00, cout}, {8'h00, (ix >= iy)});
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule : ripple_addsub_tb